// File: doc/BRIEF.md
# Serial Memory-Card Master with Interrupting Byte Queues

This block is a byte-oriented serial master that a host processor uses to talk to a memory card over a four-wire SPI link. The host reaches it through a small register window on an APB-style bus. Bytes that the host writes are held in an eight-deep transmit queue. The serial engine takes them one at a time and shifts them out most significant bit first. In the same byte period it shifts in a byte from the card and drops it into an eight-deep receive queue. SPI mode 0 is used: the clock idles low, data is sampled on the rising edge and changed on the falling edge.

The serial clock comes from the peripheral clock. Each half period of the serial clock lasts DIV+1 peripheral cycles, so the full divisor is always even. Chip select is a host-controlled bit, so it can stay asserted across any number of back-to-back bytes. When the host only wants to read, a fill mode sends 0xFF whenever the transmit queue is empty.

Two sticky events drive a single interrupt line. The first is set when the transmit queue has handed its last byte to the shifter. The second is set when the receive queue becomes full. The host clears each one by writing 1 to it. Misuse of either queue is ignored and flagged in the same way.

Top module: `spim_card_master`

Register map, by word address on `paddr`:
- 0: data. A write pushes a byte to the transmit queue. A read returns the receive head and pops it.
- 1: control. Bit 0 asserts chip select, bit 1 enables the interrupt, bit 2 enables the 0xFF fill.
- 2: status. Bit 0 is transmit drained (write 1 to clear). Bit 1 is receive full (write 1 to clear). Bit 2 is push-overflow error (write 1 to clear). Bit 3 is pop-underflow error (write 1 to clear). Bit 4 is busy. Bit 5 is transmit empty. Bit 6 is receive empty. Bit 7 is transmit full.
- 3: divisor DIV. Its reset value is 1.

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, irq is 0, status reads 0x60 and the divisor reads 1.
- R2: Each byte goes out on mosi most significant bit first and stays stable while sclk is high. The byte captured from miso on the eight rising edges is delivered to the receive queue, with its first sampled bit as the most significant bit.
- R3: sclk idles low, and while a byte is in progress its rising edges are 2*(DIV+1) peripheral cycles apart.
- R4: cs_n is the inverse of control bit 0. It changes only after a write to the control register, and it stays low across back-to-back bytes.
- R5: With control bit 2 set, chip select asserted and the transmit queue empty, the engine still runs byte periods and sends 0xFF.
- R6: Status bit 0 is set when the last queued transmit byte moves into the shifter. It stays set until the host writes 1 to it.
- R7: Status bit 1 is set when the eighth entry enters the receive queue. No new byte period starts while the receive queue is full.
- R8: irq is high exactly when control bit 1 is set and status bit 0 or status bit 1 is set.
- R9: A push to a full transmit queue is dropped and sets status bit 2. The queued contents are unchanged.
- R10: A pop from an empty receive queue changes no queue state and sets status bit 3.
- R11: Both queues keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 2 | Register word address |
| pwdata | input | 8 | Bus write data |
| prdata | output | 8 | Bus read data |
| irq | output | 1 | Interrupt request |
| cs_n | output | 1 | Card chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to card |
| miso | input | 1 | Serial data from card |

## Verification
The assertions assume that every bus access has a setup cycle followed by a single access cycle with psel held. They also assume that miso settles before each rising sclk edge. The stimulus drives the bus only on falling pclk edges, with a one-cycle setup phase. The card is modelled as a loopback that returns mosi, optionally inverted, so miso changes only when mosi changes, and mosi changes only while sclk is low.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_DIV  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;

  typedef struct packed {
    logic fill_en;
    logic irq_en;
    logic cs_on;
  } ctrl_t;

  typedef struct packed {
    logic rx_udf;
    logic tx_ovf;
    logic rx_full;
    logic tx_done;
  } flags_t;
endpackage

// File: rtl/spim_rst_sync.sv
module spim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + CNT_W'(1);
    if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;

  // R9: a push into a full queue leaves its occupancy untouched
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> $stable(cnt_q))
    else $error("push into full queue changed occupancy");

  // R10: a pop from an empty queue leaves it empty
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (cnt_q == '0))
    else $error("pop from empty queue changed occupancy");
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);
  eng_state_e        st_q, st_d;
  logic [DIV_W-1:0]  hcnt_q, hcnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              sclk_q, sclk_d;
  logic [BYTE_W-1:0] tsr_q, tsr_d, rsr_q, rsr_d;
  logic              half_end, last_fall;

  assign half_end  = (st_q == ENG_SHIFT) && (hcnt_q == div);
  assign last_fall = half_end && sclk_q && (bit_q == BIT_W'(BYTE_W - 1));

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    tsr_d  = tsr_q;
    rsr_d  = rsr_q;
    case (st_q)
      ENG_IDLE: begin
        if (start) begin
          st_d   = ENG_SHIFT;
          tsr_d  = tx_byte;
          hcnt_d = '0;
          bit_d  = '0;
          sclk_d = 1'b0;
        end
      end
      ENG_SHIFT: begin
        if (half_end) begin
          hcnt_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rsr_d  = {rsr_q[BYTE_W-2:0], miso};
          end else begin
            sclk_d = 1'b0;
            if (last_fall) begin
              st_d = ENG_IDLE;
            end else begin
              bit_d = bit_q + BIT_W'(1);
              tsr_d = {tsr_q[BYTE_W-2:0], 1'b1};
            end
          end
        end else begin
          hcnt_d = hcnt_q + DIV_W'(1);
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      hcnt_q <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      tsr_q  <= '1;
      rsr_q  <= '0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      tsr_q  <= tsr_d;
      rsr_q  <= rsr_d;
    end
  end

  assign sclk     = sclk_q;
  assign mosi     = tsr_q[BYTE_W-1];
  assign busy     = (st_q == ENG_SHIFT);
  assign rx_valid = last_fall;
  assign rx_byte  = rsr_q;

  // R3: clock idles low outside a byte period
  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE) |-> !sclk_q)
    else $error("sclk high while idle");

  // R2: data line holds while the clock is high
  a_r2_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(tsr_q[BYTE_W-1]))
    else $error("mosi moved while sclk high");
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [1:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [DATA_W-1:0] rx_head,
  input  logic              busy,
  input  logic              tx_drain_ev,
  input  logic              rx_fill_ev,
  output logic              tx_push,
  output logic              rx_pop,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] div,
  output logic              irq,
  output logic              cs_n
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int FLAG_W = $bits(flags_t);

  reg_sel_e          sel;
  logic              wr, rd, wr_ctrl, wr_stat;
  ctrl_t             ctrl_q, ctrl_d;
  flags_t            flg_q, flg_d, flg_set;
  logic [DATA_W-1:0] div_q, div_d;

  assign sel     = reg_sel_e'(paddr);
  assign wr      = psel && penable && pwrite;
  assign rd      = psel && penable && !pwrite;
  assign wr_ctrl = wr && (sel == REG_CTRL);
  assign wr_stat = wr && (sel == REG_STAT);
  assign tx_push = wr && (sel == REG_DATA);
  assign rx_pop  = rd && (sel == REG_DATA);

  always_comb begin
    flg_set         = '0;
    flg_set.tx_done = tx_drain_ev;
    flg_set.rx_full = rx_fill_ev;
    flg_set.tx_ovf  = tx_push && tx_full;
    flg_set.rx_udf  = rx_pop && rx_empty;

    ctrl_d = wr_ctrl ? ctrl_t'(pwdata[CTRL_W-1:0]) : ctrl_q;
    div_d  = (wr && (sel == REG_DIV)) ? pwdata : div_q;
    flg_d  = flg_q;
    if (wr_stat) flg_d = flg_q & ~flags_t'(pwdata[FLAG_W-1:0]);
    flg_d = flg_d | flg_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DATA_W'(1);
      flg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      flg_q  <= flg_d;
    end
  end

  always_comb begin
    prdata = '0;
    case (sel)
      REG_DATA: prdata = rx_empty ? '0 : rx_head;
      REG_CTRL: prdata = DATA_W'(ctrl_q);
      REG_STAT: prdata = DATA_W'({tx_full, rx_empty, tx_empty, busy, flg_q});
      REG_DIV:  prdata = div_q;
      default:  prdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign div  = div_q;
  assign irq  = ctrl_q.irq_en && (flg_q.tx_done || flg_q.rx_full);
  assign cs_n = !ctrl_q.cs_on;

  // R4: chip select moves only as a result of a control write
  a_r4_cs_on_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> $past(wr_ctrl))
    else $error("cs_n changed without control write");

  // R6: drained flag is sticky until a write of 1 clears it
  a_r6_drain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q.tx_done && !(wr_stat && pwdata[0])) |=> flg_q.tx_done)
    else $error("drained flag dropped without clear");

  // R7: full flag is sticky until a write of 1 clears it
  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q.rx_full && !(wr_stat && pwdata[1])) |=> flg_q.rx_full)
    else $error("full flag dropped without clear");
endmodule

// File: rtl/spim_card_master.sv
module spim_card_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [1:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic              rst_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] div, tx_head, rx_head, rx_byte, tx_byte;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_push, rx_pop, tx_pop, start, busy, rx_valid;
  logic              tx_drain_ev, rx_fill_ev;

  spim_rst_sync #(.STAGES(2)) u_rst (
    .clk(pclk), .arst_n(presetn), .rst_n(rst_n)
  );

  spim_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(pclk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_head(rx_head), .busy(busy),
    .tx_drain_ev(tx_drain_ev), .rx_fill_ev(rx_fill_ev),
    .tx_push(tx_push), .rx_pop(rx_pop),
    .ctrl(ctrl), .div(div), .irq(irq), .cs_n(cs_n)
  );

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(pclk), .rst_n(rst_n),
    .push(tx_push), .wdata(pwdata), .pop(tx_pop),
    .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(pclk), .rst_n(rst_n),
    .push(rx_valid), .wdata(rx_byte), .pop(rx_pop),
    .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  assign start   = !busy && ctrl.cs_on && !rx_full && (!tx_empty || ctrl.fill_en);
  assign tx_pop  = start && !tx_empty;
  assign tx_byte = tx_empty ? '1 : tx_head;

  assign tx_drain_ev = tx_pop && (tx_cnt == CNT_W'(1)) && !(tx_push && !tx_full);
  assign rx_fill_ev  = rx_valid && (rx_cnt == CNT_W'(FIFO_DEPTH - 1)) && !(rx_pop && !rx_empty);

  spim_shifter #(.BYTE_W(DATA_W), .DIV_W(DATA_W)) u_eng (
    .clk(pclk), .rst_n(rst_n), .div(div), .start(start), .tx_byte(tx_byte),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  // R7: a finished byte never meets a full receive queue
  a_r7_room_for_byte: assert property (@(posedge pclk) disable iff (!rst_n)
    rx_valid |-> !rx_full)
    else $error("received byte with no room");

  // R8: interrupt never raised while disabled
  a_r8_irq_gated: assert property (@(posedge pclk) disable iff (!rst_n)
    irq |-> ctrl.irq_en)
    else $error("irq while disabled");
endmodule

// File: tb/test_spim_card_master.sv
`timescale 1ns/1ps
module test_spim_card_master;
  logic       pclk, presetn, psel, penable, pwrite, miso_inv;
  logic [1:0] paddr;
  logic [7:0] pwdata, prdata;
  logic       irq, cs_n, sclk, mosi, miso;
  int         total, bad, cyc, prev_rise, last_rise;
  logic       sclk_d;

  // divisor, byte, invert flag
  localparam logic [16:0] VECS [0:5] = '{
    {8'd0, 8'hA5, 1'b0}, {8'd1, 8'h3C, 1'b1}, {8'd3, 8'h81, 1'b0},
    {8'd7, 8'h00, 1'b1}, {8'd2, 8'hFE, 1'b0}, {8'd0, 8'h5A, 1'b1}
  };

  spim_card_master i_spim_card_master (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq(irq), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign miso = mosi ^ miso_inv;

  initial pclk = 1'b0;
  always #2.5 pclk = ~pclk;

  always @(posedge pclk) begin
    cyc    <= cyc + 1;
    sclk_d <= sclk;
    if (sclk && !sclk_d) begin
      prev_rise <= last_rise;
      last_rise <= cyc;
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    finish_run();
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_stat(input int b, input logic v);
    logic [7:0] s;
    for (int n = 0; n < 5000; n++) begin
      apb_read(2'd2, s);
      if (s[b] == v) return;
    end
  endtask

  initial begin
    logic [7:0] r, exp_rx;
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    miso_inv = 0; cyc = 0; prev_rise = 0; last_rise = 0; sclk_d = 0;
    total = 0; bad = 0;
    repeat (4) @(negedge pclk);
    presetn = 1;
    repeat (4) @(negedge pclk);

    // R1 reset state
    check("R1 cs_n", cs_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 irq", irq, 0);
    apb_read(2'd2, r); check("R1 status", r, 8'h60);
    apb_read(2'd3, r); check("R1 divisor", r, 1);

    // vector table: R2 data path, R3 clock period, R4 chip select, R6 drained flag
    for (int i = 0; i < 6; i++) begin
      miso_inv = VECS[i][0];
      apb_write(2'd3, VECS[i][16:9]);
      apb_write(2'd0, VECS[i][8:1]);
      apb_write(2'd1, 8'h01);
      check("R4 cs low", cs_n, 0);
      wait_stat(6, 1'b0);
      exp_rx = VECS[i][8:1] ^ {8{VECS[i][0]}};
      apb_read(2'd0, r); check("R2 loop byte", r, exp_rx);
      check("R3 sclk period", last_rise - prev_rise, 2 * (VECS[i][16:9] + 1));
      apb_read(2'd2, r); check("R6 drained set", r[0], 1);
      apb_write(2'd1, 8'h00);
      check("R4 cs high", cs_n, 1);
      apb_write(2'd2, 8'h0F);
      apb_read(2'd2, r); check("R6 drained cleared", r[3:0], 0);
    end

    // R5 fill with 0xFF, R7 stall when receive queue full, R8 irq
    miso_inv = 0;
    apb_write(2'd3, 8'd0);
    apb_write(2'd1, 8'h05);
    wait_stat(1, 1'b1);
    repeat (40) @(negedge pclk);
    apb_read(2'd2, r);
    check("R7 not busy when full", r[4], 0);
    check("R7 full flag", r[1], 1);
    check("R6 no drain without pops", r[0], 0);
    check("R4 cs held low", cs_n, 0);
    check("R8 irq disabled", irq, 0);
    apb_write(2'd1, 8'h02);
    check("R8 irq raised", irq, 1);
    apb_write(2'd2, 8'h02);
    check("R8 irq cleared", irq, 0);
    for (int i = 0; i < 8; i++) begin
      apb_read(2'd0, r); check("R5 fill byte", r, 8'hFF);
    end
    apb_read(2'd2, r); check("R7 queue drained", r[6], 1);

    // R9 overflow, R11 order
    apb_write(2'd1, 8'h00);
    for (int i = 0; i < 9; i++) apb_write(2'd0, 8'h10 + 8'(i));
    apb_read(2'd2, r);
    check("R9 tx full", r[7], 1);
    check("R9 overflow flag", r[2], 1);
    apb_write(2'd1, 8'h01);
    wait_stat(1, 1'b1);
    repeat (40) @(negedge pclk);
    apb_write(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      apb_read(2'd0, r); check("R11 order", r, 8'h10 + 8'(i));
    end
    apb_read(2'd2, r);
    check("R9 dropped byte absent", r[5], 1);
    check("R6 drained after burst", r[0], 1);
    apb_write(2'd2, 8'h01);
    apb_read(2'd2, r); check("R6 w1c only bit0", r[3:0], 4'b0110);
    apb_write(2'd2, 8'h0F);

    // R10 underflow
    apb_read(2'd0, r);
    apb_read(2'd2, r);
    check("R10 underflow flag", r[3], 1);
    check("R10 still empty", r[6], 1);
    apb_write(2'd0, 8'hC3);
    apb_write(2'd1, 8'h01);
    wait_stat(6, 1'b0);
    apb_read(2'd0, r); check("R10 queue intact", r, 8'hC3);
    apb_read(2'd2, r); check("R10 empty after one", r[6], 1);

    finish_run();
  end
endmodule